// File: doc/BRIEF.md
# Full-Duplex Register-Mapped Serial Port

This block is an asynchronous serial port for a small processor. The processor reaches it through a two-address register bus: one address holds a control and status byte, the other is a shared data-buffer address. A write to the data address sends a byte on the transmit line. A read from the same address returns the last byte taken off the receive line. The transmit and receive paths run independently, and a frame can go out while another comes in.

A frame is one low start bit, then the data bits least significant first, then an optional ninth bit, then one high stop bit. The line idles high. In the 9-bit frame mode the ninth transmitted bit is set by software, and the ninth received bit is kept for software to inspect. An external baud tick arrives 16 times per bit and sets all bit timing. Transmit-done and receive-done flags stay set until software clears them. Their OR, gated by an enable input, forms the single interrupt output.

Top module: `uart_core`

## Requirements
- R1: After reset, txd is high, irq is low, and the control byte and the data address both read 0.
- R2: A write to the data address (bus_addr=1) starts a frame on txd: a low start bit, then 8 data bits LSB first, then a high stop bit. Each bit lasts 16 baud ticks. A write during a frame restarts it.
- R3: With the frame-mode bit (control bit 4) set, the value of the send-ninth-bit (control bit 2) goes out between the data bits and the stop bit.
- R4: The transmit-done flag (control bit 0) is still 0 at the middle of the stop bit and becomes 1 when the stop bit ends.
- R5: A frame received with a high stop bit sets the receive-done flag (control bit 1) and places the byte at the data address. In 9-bit mode the received ninth bit appears in control bit 3. In 8-bit mode that bit reads 0.
- R6: A read of the data address returns the receive buffer and never the byte being transmitted.
- R7: Control bits 0 and 1 stay set until software writes a 0 to them through the control address (bus_addr=0).
- R8: irq is high exactly when irq_en is high and control bit 0 or bit 1 is set.
- R9: A low pulse on rxd that is high again by the middle of the start bit is ignored. The receiver then accepts the next real frame.
- R10: A frame whose stop bit samples low is discarded. The receive buffer and control bit 1 keep their old values.
- R11: The receive buffer keeps the previous byte readable while the next frame is being shifted in.
- R12: A good frame that completes while control bit 1 is set replaces the buffer and sets the overrun bit (control bit 5).
- R13: A transmission and a reception that overlap in time both complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| bus_addr | input | 1 | 0 = control byte, 1 = data buffer |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected address |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Combined completion interrupt |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The properties assume that baud_tick is a single-cycle pulse and that software does not change the frame mode while a frame is in flight. They also assume that any write to the control address carries the flag values software intends, because a written 0 clears a flag and a written 1 sets it. The bench makes baud_tick a free-running pulse every fourth clock. It changes the control byte only between frames. Every serial frame it drives lasts exactly 64 clocks per bit, so midpoint sampling has a wide margin. The one exception is the deliberately short false-start pulse.

// File: rtl/uart_pkg.sv
`timescale 1ns/1ps
package uart_pkg;
  typedef enum logic [2:0] {
    RX_WAIT,
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;

  localparam int CTL_TI    = 0;
  localparam int CTL_RI    = 1;
  localparam int CTL_TB8   = 2;
  localparam int CTL_RB8   = 3;
  localparam int CTL_MODE9 = 4;
  localparam int CTL_OVR   = 5;

  localparam logic ADDR_CTL  = 1'b0;
  localparam logic ADDR_DATA = 1'b1;
endpackage

// File: rtl/uart_tx.sv
`timescale 1ns/1ps
module uart_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic              mode9,
  input  logic              bit9,
  input  logic [DATA_W-1:0] din,
  output logic              txd,
  output logic              done
);
  localparam int SH_W = DATA_W + 2;
  localparam int CW   = $clog2(OSR);

  logic [SH_W-1:0] sh_q, sh_d, sh_next;
  logic            busy_q, busy_d;
  logic            start_q, start_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  // remaining bits after one shift; all zero means the stop bit has gone out
  assign sh_next = sh_q >> 1;

  always_comb begin
    sh_d    = sh_q;
    busy_d  = busy_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    done    = 1'b0;
    if (load) begin
      sh_d    = mode9 ? {1'b1, bit9, din} : {1'b0, 1'b1, din};
      busy_d  = 1'b1;
      start_d = 1'b1;
      cnt_d   = '0;
    end else if (busy_q && tick) begin
      if (cnt_q == CW'(OSR - 1)) begin
        cnt_d = '0;
        if (start_q) begin
          start_d = 1'b0;
        end else begin
          sh_d = sh_next;
          if (sh_next == '0) begin
            busy_d = 1'b0;
            done   = 1'b1;
          end
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sh_q    <= sh_d;
      busy_q  <= busy_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
    end
  end

  assign txd = !busy_q || (!start_q && sh_q[0]);
endmodule

// File: rtl/uart_rx.sv
`timescale 1ns/1ps
module uart_rx
  import uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              mode9,
  output logic              done,
  output logic              stop_ok,
  output logic [DATA_W-1:0] data,
  output logic              bit9
);
  localparam int CW  = $clog2(OSR);
  localparam int IW  = $clog2(DATA_W + 1);
  localparam int MID = OSR / 2 - 1;

  rx_state_t       st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [DATA_W:0] sh_q, sh_d;
  logic            s1_q, s2_q;
  logic [IW-1:0]   last_idx;

  assign last_idx = mode9 ? IW'(DATA_W) : IW'(DATA_W - 1);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    done    = 1'b0;
    stop_ok = 1'b0;
    case (st_q)
      RX_WAIT: if (s2_q) st_d = RX_IDLE;
      RX_IDLE: begin
        cnt_d = '0;
        if (tick && !s2_q) st_d = RX_START;
      end
      RX_START: if (tick) begin
        if (cnt_q == CW'(MID)) begin
          cnt_d = '0;
          idx_d = '0;
          st_d  = s2_q ? RX_IDLE : RX_DATA;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_DATA: if (tick) begin
        if (cnt_q == CW'(OSR - 1)) begin
          cnt_d = '0;
          sh_d  = {s2_q, sh_q[DATA_W:1]};
          idx_d = idx_q + 1'b1;
          if (idx_q == last_idx) st_d = RX_STOP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_STOP: if (tick) begin
        if (cnt_q == CW'(OSR - 1)) begin
          done    = 1'b1;
          stop_ok = s2_q;
          st_d    = s2_q ? RX_IDLE : RX_WAIT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      s1_q  <= rxd;
      s2_q  <= s1_q;
    end
  end

  assign data = mode9 ? sh_q[DATA_W-1:0] : sh_q[DATA_W:1];
  assign bit9 = sh_q[DATA_W];
endmodule

// File: rtl/uart_core.sv
`timescale 1ns/1ps
module uart_core
  import uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_en,
  output logic              irq,
  input  logic              rxd,
  output logic              txd
);
  logic ti_q, ti_d, ri_q, ri_d, tb8_q, tb8_d, rb8_q, rb8_d;
  logic mode9_q, mode9_d, ovr_q, ovr_d;
  logic [DATA_W-1:0] rbuf_q, rbuf_d, ctl_rd;
  logic wr_ctl, wr_dat, tx_done, rx_done, rx_stop_ok, rx_bit9, rx_good;
  logic [DATA_W-1:0] rx_data;

  assign wr_ctl  = bus_wr && (bus_addr == ADDR_CTL);
  assign wr_dat  = bus_wr && (bus_addr == ADDR_DATA);
  assign rx_good = rx_done && rx_stop_ok;

  uart_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(wr_dat),
    .mode9(mode9_q), .bit9(tb8_q), .din(bus_wdata),
    .txd(txd), .done(tx_done)
  );

  uart_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd),
    .mode9(mode9_q), .done(rx_done), .stop_ok(rx_stop_ok),
    .data(rx_data), .bit9(rx_bit9)
  );

  // hardware events win over a same-cycle software write
  always_comb begin
    ti_d    = tx_done ? 1'b1 : (wr_ctl ? bus_wdata[CTL_TI] : ti_q);
    ri_d    = rx_good ? 1'b1 : (wr_ctl ? bus_wdata[CTL_RI] : ri_q);
    ovr_d   = (rx_good && ri_q) ? 1'b1 : (wr_ctl ? bus_wdata[CTL_OVR] : ovr_q);
    tb8_d   = wr_ctl ? bus_wdata[CTL_TB8]   : tb8_q;
    mode9_d = wr_ctl ? bus_wdata[CTL_MODE9] : mode9_q;
    rb8_d   = rx_good ? (mode9_q && rx_bit9) : rb8_q;
    rbuf_d  = rx_good ? rx_data : rbuf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ti_q    <= 1'b0;
      ri_q    <= 1'b0;
      tb8_q   <= 1'b0;
      rb8_q   <= 1'b0;
      mode9_q <= 1'b0;
      ovr_q   <= 1'b0;
      rbuf_q  <= '0;
    end else begin
      ti_q    <= ti_d;
      ri_q    <= ri_d;
      tb8_q   <= tb8_d;
      rb8_q   <= rb8_d;
      mode9_q <= mode9_d;
      ovr_q   <= ovr_d;
      rbuf_q  <= rbuf_d;
    end
  end

  always_comb begin
    ctl_rd            = '0;
    ctl_rd[CTL_TI]    = ti_q;
    ctl_rd[CTL_RI]    = ri_q;
    ctl_rd[CTL_TB8]   = tb8_q;
    ctl_rd[CTL_RB8]   = rb8_q;
    ctl_rd[CTL_MODE9] = mode9_q;
    ctl_rd[CTL_OVR]   = ovr_q;
  end

  assign bus_rdata = (bus_addr == ADDR_DATA) ? rbuf_q : ctl_rd;
  assign irq       = irq_en && (ti_q || ri_q);
endmodule

// File: rtl/uart_core_chk.sv
`timescale 1ns/1ps
module uart_core_chk
  import uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_addr,
  input logic              bus_wr,
  input logic              irq_en,
  input logic              irq,
  input logic              txd,
  input logic              ti,
  input logic              ri,
  input logic              ovr,
  input logic [DATA_W-1:0] rbuf,
  input logic              rx_good
);
  logic ctl_write;
  assign ctl_write = bus_wr && (bus_addr == ADDR_CTL);

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_DATA) |=> !txd); // R2
  AST_TI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ti && !ctl_write) |=> ti); // R7
  AST_RI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ri && !ctl_write) |=> ri); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R8
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ti || ri)); // R8
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_good |=> $stable(rbuf)); // R10
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr && !ctl_write) |=> (!ovr || $past(ri))); // R12
endmodule

bind uart_core uart_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .irq_en(irq_en), .irq(irq), .txd(txd), .ti(ti_q), .ri(ri_q),
  .ovr(ovr_q), .rbuf(rbuf_q), .rx_good(rx_good)
);

// File: tb/uart_core_test.sv
`timescale 1ns/1ps
module uart_core_test;
  localparam int BITCLK = 64;

  logic       clk, rst_n, baud_tick, bus_addr, bus_wr, irq_en, irq, txd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       loop_en, drv_rx, rxd;
  int         n_chk, n_fail;
  logic [1:0] tdiv;

  assign rxd = loop_en ? txd : drv_rx;

  uart_core uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_en(irq_en), .irq(irq), .rxd(rxd), .txd(txd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) tdiv <= 2'd0;
    else tdiv <= tdiv + 2'd1;
  end
  assign baud_tick = rst_n && (tdiv == 2'd3);

  // {mode9, ninth bit, data}
  localparam logic [9:0] VEC [0:5] = '{
    {1'b0, 1'b0, 8'h55}, {1'b1, 1'b1, 8'hA3}, {1'b1, 1'b0, 8'h00},
    {1'b0, 1'b0, 8'hFF}, {1'b1, 1'b1, 8'h80}, {1'b0, 1'b0, 8'h01}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic send_rx(input logic [7:0] d, input logic b9, input logic m9, input logic stp);
    @(negedge clk);
    drv_rx = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      drv_rx = d[i];
      repeat (BITCLK) @(negedge clk);
    end
    if (m9) begin
      drv_rx = b9;
      repeat (BITCLK) @(negedge clk);
    end
    drv_rx = stp;
    repeat (BITCLK) @(negedge clk);
    drv_rx = 1'b1;
  endtask

  // returns at the middle of the stop bit
  task automatic cap_tx(input logic m9, output logic [7:0] d, output logic b9, output logic stp);
    wait (txd == 1'b0);
    repeat (BITCLK + BITCLK/2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      d[i] = txd;
      repeat (BITCLK) @(negedge clk);
    end
    b9 = 1'b0;
    if (m9) begin
      b9 = txd;
      repeat (BITCLK) @(negedge clk);
    end
    stp = txd;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rd, cd;
    logic       cb, cs;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; bus_addr = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    irq_en = 1'b0; loop_en = 1'b0; drv_rx = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    bus_read(1'b0, rd); check(rd == 8'h00, "R1 ctrl", rd, 0);
    bus_read(1'b1, rd); check(rd == 8'h00, "R1 data", rd, 0);
    check(txd == 1'b1, "R1 txd", txd, 1);
    irq_en = 1'b1; #1;
    check(irq == 1'b0, "R1 irq", irq, 0);
    irq_en = 1'b0;

    // table walk in loopback: R2 R3 R4 R5
    loop_en = 1'b1;
    for (int v = 0; v < 6; v++) begin
      logic m9, b8;
      logic [7:0] dv;
      {m9, b8, dv} = VEC[v];
      bus_write(1'b0, {3'b000, m9, 1'b0, b8, 2'b00});
      bus_write(1'b1, dv);
      cap_tx(m9, cd, cb, cs);
      check(cd == dv, "R2 tx data", cd, dv);
      check(cs == 1'b1, "R2 tx stop", cs, 1);
      if (m9) check(cb == b8, "R3 tx ninth bit", cb, b8);
      bus_read(1'b0, rd); check(rd[0] == 1'b0, "R4 TI early", rd[0], 0);
      repeat (48) @(negedge clk);
      bus_read(1'b0, rd);
      check(rd[0] == 1'b1, "R4 TI set", rd[0], 1);
      check(rd[1] == 1'b1, "R5 RI set", rd[1], 1);
      check(rd[3] == (m9 & b8), "R5 RB8", rd[3], m9 & b8);
      bus_read(1'b1, rd); check(rd == dv, "R5 rx data", rd, dv);
    end
    loop_en = 1'b0;
    repeat (10) @(negedge clk);

    // R6: data read returns receive buffer while transmitting
    bus_write(1'b0, 8'h00);
    bus_write(1'b1, 8'h3C);
    bus_read(1'b1, rd); check(rd == 8'h01, "R6 read not tx reg", rd, 8'h01);
    cap_tx(1'b0, cd, cb, cs);
    check(cd == 8'h3C, "R2 tx data restart-free", cd, 8'h3C);
    repeat (48) @(negedge clk);

    // R7 sticky TI and R8 irq gating
    repeat (300) @(negedge clk);
    bus_read(1'b0, rd); check(rd[0] == 1'b1, "R7 TI sticky", rd[0], 1);
    #1 check(irq == 1'b0, "R8 irq masked", irq, 0);
    irq_en = 1'b1; #1;
    check(irq == 1'b1, "R8 irq on", irq, 1);
    bus_write(1'b0, 8'h00);
    bus_read(1'b0, rd); check(rd[0] == 1'b0, "R7 TI cleared", rd[0], 0);
    #1 check(irq == 1'b0, "R8 irq off", irq, 0);
    irq_en = 1'b0;

    // R9 false start
    @(negedge clk); drv_rx = 1'b0;
    repeat (20) @(negedge clk); drv_rx = 1'b1;
    repeat (800) @(negedge clk);
    bus_read(1'b0, rd); check(rd[1] == 1'b0, "R9 no RI on glitch", rd[1], 0);
    bus_read(1'b1, rd); check(rd == 8'h01, "R9 buffer kept", rd, 8'h01);
    send_rx(8'h96, 1'b0, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    bus_read(1'b1, rd); check(rd == 8'h96, "R9 next frame ok", rd, 8'h96);

    // R10 bad stop bit
    bus_write(1'b0, 8'h00);
    send_rx(8'h3A, 1'b0, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    bus_read(1'b0, rd); check(rd[1] == 1'b0, "R10 RI unchanged", rd[1], 0);
    bus_read(1'b1, rd); check(rd == 8'h96, "R10 buffer unchanged", rd, 8'h96);

    // R11 double buffering, R12 overrun
    send_rx(8'h5A, 1'b0, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    bus_read(1'b0, rd); check(rd[5] == 1'b0, "R12 no overrun yet", rd[5], 0);
    fork
      send_rx(8'hC3, 1'b0, 1'b0, 1'b1);
      begin
        repeat (300) @(negedge clk);
        bus_read(1'b1, rd); check(rd == 8'h5A, "R11 old byte during rx", rd, 8'h5A);
      end
    join
    repeat (20) @(negedge clk);
    bus_read(1'b1, rd); check(rd == 8'hC3, "R12 overwrite", rd, 8'hC3);
    bus_read(1'b0, rd); check(rd[5] == 1'b1, "R12 overrun set", rd[5], 1);

    // R13 full duplex
    bus_write(1'b0, 8'h00);
    fork
      begin
        bus_write(1'b1, 8'h6B);
        cap_tx(1'b0, cd, cb, cs);
      end
      send_rx(8'h29, 1'b0, 1'b0, 1'b1);
    join
    repeat (48) @(negedge clk);
    check(cd == 8'h6B, "R13 tx byte", cd, 8'h6B);
    bus_read(1'b1, rd); check(rd == 8'h29, "R13 rx byte", rd, 8'h29);
    bus_read(1'b0, rd); check(rd[1:0] == 2'b11, "R13 both flags", rd[1:0], 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule